// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Character Timeout

This block holds the received-byte queue of a 16550-style serial port, together with the logic that decides when the queue is worth servicing. A deserialiser hands it whole bytes and break indications. The processor drains it through a receive-buffer read strobe. The block keeps the data-ready, break and overrun status bits and reports the current fill count. It also reports the trigger level selected by the FIFO control value and raises a timeout-pending flag when data has sat unread for too long.

The FIFO control value is written through its own strobe. Its enable bit switches the block between a 16-entry queue and a single holding register. Two self-clearing bits flush the receive queue and request a flush of the transmit queue, which lives in another block. The top two bits pick the trigger level.

The character time is worked out from the low four bits of the line control value. The timeout is measured in bit ticks supplied by the baud generator: the flag rises once four character times' worth of ticks have gone by since the last arrival or read. The interrupt prioritiser sits downstream and only sees the flags.

Top module: `rx_fifo_ctl`

## Requirements
- R1: FIFO control bits [7:6] give the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes, shown on `trig_level`.
- R2: In FIFO mode (control bit 0 = 1), bytes come out in arrival order. `fifo_count` follows each push and pop, and an arrival sets data-ready.
- R3: A byte arriving at a full queue (16 entries, no pop in the same cycle) is dropped, the stored bytes stay unchanged and the overrun flag is set. A line-status read (`lsr_rd`) clears both overrun and break.
- R4: A break indication enqueues the byte 0x00 and sets both the break and data-ready flags.
- R5: In FIFO mode with data queued, `timeout_pend` rises when the number of bit ticks since the last arrival or read reaches 4 × frame bits, where frame bits = 1 + (line_cfg[1:0]+5) + line_cfg[3] + (line_cfg[2] ? 2 : 1). Before that count is reached the flag stays low.
- R6: A receive-buffer read pops one byte and clears `timeout_pend`. If the queue becomes empty, data-ready and break clear. If data remains, the tick count restarts from zero.
- R7: A read from an empty queue in FIFO mode returns 0x00.
- R8: A write that changes control bit 0 flushes the receive queue and pulses `tx_flush` for one cycle. Control bit 1 flushes the receive queue and clears data-ready, break and timeout-pending. Control bit 2 pulses `tx_flush`.
- R9: Only control bits 7, 6, 3 and 0 are kept (`fcr_value` = written value & 0xC9). Bits 1 and 2 act once and do not stick.
- R10: With the FIFO disabled, a single holding register takes each arrival and `rd_data` shows it. An arrival while data-ready is set overwrites the register and sets overrun. A read clears data-ready.
- R11: After reset, all flags are 0, `fifo_count` is 0, `fcr_value` is 0x00 (holding-register mode) and `trig_level` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_write | input | 1 | Write strobe for the FIFO control value |
| cfg_wdata | input | 8 | FIFO control value being written |
| line_cfg | input | 4 | Line control bits: [1:0] data length − 5, [2] two stop bits, [3] parity on |
| bit_tick | input | 1 | One pulse per bit period |
| rx_valid | input | 1 | Deserialiser delivers a byte |
| rx_break | input | 1 | Deserialiser reports a break (wins over rx_valid) |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | Receive-buffer read strobe |
| rd_data | output | 8 | Byte returned by the read in the same cycle |
| lsr_rd | input | 1 | Line-status read; clears overrun and break |
| data_ready | output | 1 | Data-ready flag |
| break_flag | output | 1 | Break flag |
| overrun_flag | output | 1 | Overrun flag |
| timeout_pend | output | 1 | Character-timeout pending |
| fifo_count | output | 5 | Bytes currently queued |
| trig_level | output | 4 | Selected trigger level in bytes |
| fcr_value | output | 8 | Retained FIFO control bits |
| tx_flush | output | 1 | One-cycle request to flush the transmit queue |

## Verification
Corruption of the queue pointers or the count shows at `rd_data` on the very next read: bytes come out in the wrong order or repeat. The same fault also shows as a `fifo_count` and data-ready pair that disagree in the cycle after the faulty push or pop. A tick counter that is off by one moves the rise of `timeout_pend` by exactly one tick. The bench therefore samples the flag one tick before and one tick after the limit, for two frame formats. A stale flag after a flush or a read shows on the flags one cycle after the write or read strobe.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int          CTL_EN_BIT  = 0;
    localparam int          CTL_RXC_BIT = 1;
    localparam int          CTL_TXC_BIT = 2;
    localparam logic [7:0]  CTL_KEEP    = 8'hC9;
    localparam int          TMR_W       = 6;   // 4 x 12 bits max = 48

    // bits per character: start + data + optional parity + stop
    function automatic logic [3:0] frame_bits(input logic [3:0] lc);
        logic [3:0] n;
        n = 4'd1 + {2'b00, lc[1:0]} + 4'd5 + {3'b000, lc[3]} + (lc[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

    function automatic logic [3:0] trig_decode(input logic [1:0] sel);
        logic [3:0] lv;
        case (sel)
            2'b00:   lv = 4'd1;
            2'b01:   lv = 4'd4;
            2'b10:   lv = 4'd8;
            default: lv = 4'd14;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,   // power of two
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic                     pop,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            head,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     push_ok,
    output logic                     pop_ok
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t          p_d, p_q;
    logic [DW-1:0] mem [DEPTH];
    logic          full;

    assign full    = (p_q.cnt == (AW+1)'(DEPTH));
    assign pop_ok  = pop && (p_q.cnt != '0) && !clr;
    assign push_ok = push && (!full || pop_ok) && !clr;

    always_comb begin
        p_d = p_q;
        if (clr) begin
            p_d = '0;
        end else begin
            if (push_ok) p_d.wp = p_q.wp + 1'b1;
            if (pop_ok)  p_d.rp = p_q.rp + 1'b1;
            p_d.cnt = p_q.cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[p_q.wp] <= wdata;
    end

    assign head  = mem[p_q.rp];
    assign count = p_q.cnt;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= (AW+1)'(DEPTH)); // R2

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)                            cnt_d = '0;
        else if (run && tick && cnt_q < limit)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q >= limit);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(run && tick)) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_write,
    input  logic [7:0]              cfg_wdata,
    input  logic [3:0]              line_cfg,
    input  logic                    bit_tick,
    input  logic                    rx_valid,
    input  logic                    rx_break,
    input  logic [DW-1:0]           rx_data,
    input  logic                    rd_en,
    output logic [DW-1:0]           rd_data,
    input  logic                    lsr_rd,
    output logic                    data_ready,
    output logic                    break_flag,
    output logic                    overrun_flag,
    output logic                    timeout_pend,
    output logic [$clog2(DEPTH):0]  fifo_count,
    output logic [3:0]              trig_level,
    output logic [7:0]              fcr_value,
    output logic                    tx_flush
);
    import rxf_pkg::*;

    localparam int CNTW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [7:0]    ctl;
        logic [DW-1:0] hold;
        logic          dr;
        logic          bi;
        logic          oe;
        logic          pend;
        logic          txf;
    } st_t;

    st_t st_d, st_q;

    logic            fifo_en, en_flip, rx_clr, tx_clr, arrive;
    logic            push, pop, push_ok, pop_ok, expired, tmr_restart;
    logic [DW-1:0]   arr_byte, head;
    logic [CNTW-1:0] count;
    logic [TMR_W-1:0] limit;

    assign fifo_en  = st_q.ctl[CTL_EN_BIT];
    assign en_flip  = cfg_write && (cfg_wdata[CTL_EN_BIT] != fifo_en);
    assign rx_clr   = cfg_write && (cfg_wdata[CTL_RXC_BIT] || en_flip);
    assign tx_clr   = cfg_write && (cfg_wdata[CTL_TXC_BIT] || en_flip);
    assign arrive   = rx_valid || rx_break;
    assign arr_byte = rx_break ? '0 : rx_data;
    assign push     = fifo_en && arrive;
    assign pop      = fifo_en && rd_en;
    assign limit    = {frame_bits(line_cfg), 2'b00};
    assign tmr_restart = arrive || rd_en || rx_clr;

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(push), .pop(pop),
        .wdata(arr_byte), .head(head), .count(count),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    rxf_timer #(.CW(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
        .run(fifo_en && (count != '0)), .tick(bit_tick),
        .limit(limit), .expired(expired)
    );

    always_comb begin
        st_d     = st_q;
        st_d.txf = tx_clr;
        if (lsr_rd) begin
            st_d.oe = 1'b0;
            st_d.bi = 1'b0;
        end
        if (fifo_en) begin
            if (rd_en) st_d.pend = 1'b0;
            if (pop_ok && !push_ok && count == CNTW'(1)) begin
                st_d.dr = 1'b0;
                st_d.bi = 1'b0;
            end
            if (push) begin
                st_d.dr = 1'b1;
                if (!push_ok) st_d.oe = 1'b1;
                if (rx_break) st_d.bi = 1'b1;
            end
            if (expired && !tmr_restart) st_d.pend = 1'b1;
        end else begin
            if (rd_en) begin
                st_d.dr = 1'b0;
                st_d.bi = 1'b0;
            end
            if (arrive) begin
                if (st_q.dr && !rd_en) st_d.oe = 1'b1;
                st_d.hold = arr_byte;
                st_d.dr   = 1'b1;
                if (rx_break) st_d.bi = 1'b1;
            end
        end
        if (rx_clr) begin
            st_d.dr   = 1'b0;
            st_d.bi   = 1'b0;
            st_d.pend = 1'b0;
        end
        if (cfg_write) st_d.ctl = cfg_wdata & CTL_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data      = fifo_en ? ((count == '0) ? '0 : head) : st_q.hold;
    assign data_ready   = st_q.dr;
    assign break_flag   = st_q.bi;
    assign overrun_flag = st_q.oe;
    assign timeout_pend = st_q.pend;
    assign fifo_count   = count;
    assign trig_level   = trig_decode(st_q.ctl[7:6]);
    assign fcr_value    = st_q.ctl;
    assign tx_flush     = st_q.txf;

    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count == CNTW'(DEPTH) && rx_valid && !rd_en && !cfg_write)
        |=> (fifo_count == CNTW'(DEPTH) && overrun_flag)); // R3
    AST_BRK_HAS_DR: assert property (@(posedge clk) disable iff (!rst_n)
        break_flag |-> data_ready); // R4
    AST_PEND_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> (fifo_count != '0)); // R5
    AST_EMPTY_NO_DR: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && fifo_count == '0) |-> !data_ready); // R6
    AST_READ_CLR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rd_en) |=> !timeout_pend); // R6
    AST_CTL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write |=> (fcr_value == ($past(cfg_wdata) & 8'hC9))); // R9

endmodule

// File: tb/tb_rx_fifo_ctl.sv
module tb_rx_fifo_ctl;
    localparam int CLK_PER = 10;

    logic       clk = 0, rst_n = 0;
    logic       cfg_write = 0, bit_tick = 0, rx_valid = 0, rx_break = 0;
    logic       rd_en = 0, lsr_rd = 0;
    logic [7:0] cfg_wdata = 0, rx_data = 0, rd_data, fcr_value;
    logic [3:0] line_cfg = 4'h3, trig_level;
    logic       data_ready, break_flag, overrun_flag, timeout_pend, tx_flush;
    logic [4:0] fifo_count;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    rx_fifo_ctl dut (
        .clk(clk), .rst_n(rst_n), .cfg_write(cfg_write), .cfg_wdata(cfg_wdata),
        .line_cfg(line_cfg), .bit_tick(bit_tick), .rx_valid(rx_valid),
        .rx_break(rx_break), .rx_data(rx_data), .rd_en(rd_en), .rd_data(rd_data),
        .lsr_rd(lsr_rd), .data_ready(data_ready), .break_flag(break_flag),
        .overrun_flag(overrun_flag), .timeout_pend(timeout_pend),
        .fifo_count(fifo_count), .trig_level(trig_level), .fcr_value(fcr_value),
        .tx_flush(tx_flush)
    );

    typedef struct packed {
        logic [1:0] op;   // 0 push, 1 read, 2 break
        logic [7:0] din;
        logic [7:0] exp;
        logic [4:0] cnt;
        logic       dr;
        logic       bi;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{2'd0, 8'hA5, 8'h00, 5'd1, 1'b1, 1'b0},
        '{2'd0, 8'h3C, 8'h00, 5'd2, 1'b1, 1'b0},
        '{2'd0, 8'h7E, 8'h00, 5'd3, 1'b1, 1'b0},
        '{2'd1, 8'h00, 8'hA5, 5'd2, 1'b1, 1'b0},
        '{2'd2, 8'h00, 8'h00, 5'd3, 1'b1, 1'b1},
        '{2'd1, 8'h00, 8'h3C, 5'd2, 1'b1, 1'b1},
        '{2'd1, 8'h00, 8'h7E, 5'd1, 1'b1, 1'b1},
        '{2'd1, 8'h00, 8'h00, 5'd0, 1'b0, 1'b0},
        '{2'd1, 8'h00, 8'h00, 5'd0, 1'b0, 1'b0},
        '{2'd0, 8'h5A, 8'h00, 5'd1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        cfg_write = 1; cfg_wdata = v; cyc(); cfg_write = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_data = b; cyc(); rx_valid = 0;
    endtask

    task automatic brk();
        rx_break = 1; cyc(); rx_break = 0;
    endtask

    task automatic rd(output logic [7:0] v);
        rd_en = 1; #1 v = rd_data; cyc(); rd_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1; cyc(); bit_tick = 0;
        end
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) cyc();
        rst_n = 1; cyc();

        // R11 reset state
        check("R11 dr", data_ready, 0);
        check("R11 bi", break_flag, 0);
        check("R11 oe", overrun_flag, 0);
        check("R11 pend", timeout_pend, 0);
        check("R11 count", fifo_count, 0);
        check("R11 fcr", fcr_value, 8'h00);
        check("R11 trig", trig_level, 1);

        // R1 / R9 / R8 control value
        wr_ctl(8'hFF);
        check("R9 mask", fcr_value, 8'hC9);
        check("R8 tx pulse", tx_flush, 1);
        cyc();
        check("R8 tx pulse one cycle", tx_flush, 0);
        check("R1 sel 11", trig_level, 14);
        wr_ctl(8'h41); check("R1 sel 01", trig_level, 4);
        wr_ctl(8'h81); check("R1 sel 10", trig_level, 8);
        wr_ctl(8'h01); check("R1 sel 00", trig_level, 1);
        check("R9 no flip no tx pulse", tx_flush, 0);

        // R2 R4 R6 R7 vector walk in FIFO mode
        for (int k = 0; k < 10; k++) begin
            case (TBL[k].op)
                2'd0: push(TBL[k].din);
                2'd2: brk();
                default: begin
                    rd(v);
                    check($sformatf("R2/R7 vec%0d data", k), v, TBL[k].exp);
                end
            endcase
            check($sformatf("R2 vec%0d count", k), fifo_count, TBL[k].cnt);
            check($sformatf("R6 vec%0d dr", k), data_ready, TBL[k].dr);
            check($sformatf("R4 vec%0d bi", k), break_flag, TBL[k].bi);
        end

        // R8 receive reset bit flushes
        wr_ctl(8'h03);
        check("R8 rx reset count", fifo_count, 0);
        check("R8 rx reset dr", data_ready, 0);
        check("R8 rx reset fcr", fcr_value, 8'h01);

        // R3 overrun at full queue
        for (int i = 0; i < 16; i++) push(8'(i * 3));
        check("R3 full count", fifo_count, 16);
        check("R3 no early oe", overrun_flag, 0);
        push(8'hEE);
        check("R3 count kept", fifo_count, 16);
        check("R3 oe set", overrun_flag, 1);
        lsr_rd = 1; cyc(); lsr_rd = 0;
        check("R3 lsr read clears oe", overrun_flag, 0);
        for (int i = 0; i < 16; i++) begin
            rd(v);
            check("R3 contents kept", v, 8'(i * 3));
        end
        check("R3 drained dr", data_ready, 0);

        // R5 timeout, 8N1 -> 10 bits -> 40 ticks
        line_cfg = 4'h3;
        push(8'h11); push(8'h22);
        ticks(39);
        check("R5 before limit 8N1", timeout_pend, 0);
        ticks(1);
        check("R5 at limit 8N1", timeout_pend, 1);
        rd(v);
        check("R6 read clears pend", timeout_pend, 0);
        check("R6 read data", v, 8'h11);
        ticks(39);
        check("R6 restart before limit", timeout_pend, 0);
        ticks(1);
        check("R6 restart at limit", timeout_pend, 1);
        wr_ctl(8'h03);
        check("R8 reset clears pend", timeout_pend, 0);

        // R5 second format: 5 data, 1 stop, no parity -> 7 bits -> 28
        line_cfg = 4'h0;
        push(8'h33);
        ticks(27);
        check("R5 before limit 5N1", timeout_pend, 0);
        ticks(1);
        check("R5 at limit 5N1", timeout_pend, 1);

        // R8 enable change flushes; R10 holding register mode
        wr_ctl(8'h00);
        check("R8 flip flush count", fifo_count, 0);
        check("R8 flip tx pulse", tx_flush, 1);
        check("R8 flip clears pend", timeout_pend, 0);
        push(8'h44);
        check("R10 dr", data_ready, 1);
        check("R10 hold value", rd_data, 8'h44);
        check("R10 no overrun first", overrun_flag, 0);
        push(8'h55);
        check("R10 overrun", overrun_flag, 1);
        rd(v);
        check("R10 overwritten value", v, 8'h55);
        check("R10 read clears dr", data_ready, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule